// File: doc/BRIEF.md
# Chained Synchronous BCD Decade Counter

This block counts in binary-coded decimal, one 4-bit digit per stage, with a parameter that sets how many stages are chained. Every count change happens on the rising clock edge. A clear input and a parallel-load input are both active low and act only at the edge. Two count enables gate the advance. The first enable is shared by all digits. The second enable is per digit and forms the carry path: digit 0 takes it from the block input, and each later digit takes the terminal-count flag of the digit below it.

The terminal-count flag of a digit is combinational. It is high while that digit's carry enable is high and the digit reads nine. The flag of the top digit leaves the block as the carry output, so several blocks can be cascaded. A separate system reset clears all digits asynchronously. Its release is synchronised to the clock inside the block.

Top module: `bcd_chain`

## Requirements
- R1: While `rst_n` is low, every digit of `count` reads 0 and `carry_out` is low. After `rst_n` rises, the counter stays frozen for two more rising edges while the release is synchronised.
- R2: A rising edge with `clr_n` low sets every digit to 0, whatever the values of `load_n`, `cnt_en`, `carry_in` and `load_val`.
- R3: A rising edge with `clr_n` high and `load_n` low copies `load_val` into `count`, whatever the enables. Bits [4i+3:4i] form digit i, and any 4-bit code is accepted, including 1010 to 1111.
- R4: With `clr_n` and `load_n` both high, a digit advances only when `cnt_en` and that digit's carry enable are both high. Otherwise it holds its value.
- R5: An advancing digit steps 0,1,...,8,9 and returns from 9 to 0.
- R6: An advancing digit that holds a non-decimal code (1010 to 1111) goes to 0 at that edge. If it does not advance, it keeps the code.
- R7: `digit_tc[i]` is high exactly when digit i reads 1001 and its carry enable is high. It follows `carry_in` with no clock delay, ignores `load_n`, and stays low for codes 1010 to 1111.
- R8: Digit 0's carry enable is `carry_in`. Digit i's carry enable is `digit_tc[i-1]`. `carry_out` equals the top digit's flag. An advancing edge with every digit at 9 gives all zeros.
- R9: A clear edge while a digit's flag is high drops that flag in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous system reset, active low, released synchronously |
| clr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable shared by all digits |
| carry_in | input | 1 | Carry enable into digit 0 |
| load_val | input | 4*DIGITS | Parallel load value, digit i in bits [4i+3:4i] |
| count | output | 4*DIGITS | Current count, digit i in bits [4i+3:4i] |
| digit_tc | output | DIGITS | Terminal-count flag of each digit |
| carry_out | output | 1 | Terminal-count flag of the top digit |

## Verification
A wrong next-state in any digit shows on `count` at the very next rising edge. It also shows on the flags during the same cycle if that digit reads nine. A fault in the carry path is different: the lower digit looks correct, and only the next digit up fails to move at the wrap edge. For that reason the bench compares every digit and every flag after each edge. The flags are combinational, so a change of `carry_in` is also checked between edges, before the next clock.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIGIT_W    = 4;
  localparam int LAST_VALUE = 9;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } bcd_mode_e;
endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bcd_mode_sel.sv
module bcd_mode_sel
  import bcd_pkg::*;
(
  input  logic      clr_n,
  input  logic      load_n,
  input  logic      cep,
  input  logic      cet,
  output bcd_mode_e mode
);
  always_comb begin
    if (!clr_n)          mode = MODE_CLEAR;
    else if (!load_n)    mode = MODE_LOAD;
    else if (cep && cet) mode = MODE_COUNT;
    else                 mode = MODE_HOLD;
  end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
  import bcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               cep,
  input  logic               cet,
  input  logic [DIGIT_W-1:0] d_in,
  output logic [DIGIT_W-1:0] q,
  output logic               tc
);
  localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(LAST_VALUE);

  bcd_mode_e          mode;
  logic [DIGIT_W-1:0] q_nxt;
  logic               q_en;
  logic               at_top;

  bcd_mode_sel u_mode (
    .clr_n  (clr_n),
    .load_n (load_n),
    .cep    (cep),
    .cet    (cet),
    .mode   (mode)
  );

  // Next-state: any code at or above nine wraps to zero on an advance
  always_comb begin
    q_nxt = q;
    unique case (mode)
      MODE_CLEAR: q_nxt = '0;
      MODE_LOAD:  q_nxt = d_in;
      MODE_COUNT: q_nxt = (q >= TOP) ? '0 : q + 1'b1;
      default:    q_nxt = q;
    endcase
  end

  assign q_en = (mode != MODE_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  assign at_top = (q == TOP);
  assign tc     = at_top && cet;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (q == '0)); // R2
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> (q == $past(d_in))); // R3
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !(cep && cet)) |=> $stable(q)); // R4
  AST_DECADE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && cep && cet && q == TOP) |=> (q == '0)); // R5
  AST_NONBCD_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && cep && cet && q > TOP) |=> (q == '0)); // R6
  AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && clr_n && load_n && cep) |=> !tc); // R7
  AST_CLEAR_DROPS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !clr_n) |=> !tc); // R9
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
  import bcd_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_n,
  input  logic                      load_n,
  input  logic                      cnt_en,
  input  logic                      carry_in,
  input  logic [DIGIT_W*DIGITS-1:0] load_val,
  output logic [DIGIT_W*DIGITS-1:0] count,
  output logic [DIGITS-1:0]         digit_tc,
  output logic                      carry_out
);
  localparam int TOTAL_W = DIGIT_W * DIGITS;

  logic              rst_sync_n;
  logic [DIGITS-1:0] cet_vec;

  bcd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign cet_vec[0] = carry_in;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    if (i > 0) begin : g_link
      assign cet_vec[i] = digit_tc[i-1];
    end
    bcd_digit u_digit (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .clr_n  (clr_n),
      .load_n (load_n),
      .cep    (cnt_en),
      .cet    (cet_vec[i]),
      .d_in   (load_val[i*DIGIT_W +: DIGIT_W]),
      .q      (count[i*DIGIT_W +: DIGIT_W]),
      .tc     (digit_tc[i])
    );
  end

  assign carry_out = digit_tc[DIGITS-1];

  AST_FULL_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (carry_out && cnt_en && clr_n && load_n) |=> (count == TOTAL_W'(0))); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (count == TOTAL_W'(0) && !carry_out)); // R1
endmodule

// File: tb/bcd_chain_test.sv
module bcd_chain_test;
  localparam int DIGITS = 2;
  localparam int W      = 4 * DIGITS;

  typedef struct {
    logic [W-1:0]      cnt;
    logic [DIGITS-1:0] tc;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n, clr_n, load_n, cnt_en, carry_in;
  logic [W-1:0]      load_val;
  logic [W-1:0]      count;
  logic [DIGITS-1:0] digit_tc;
  logic              carry_out;

  int   n_run  = 0;
  int   n_fail = 0;
  exp_t sb_q[$];
  logic [3:0] m [DIGITS];

  always #2.5 clk = ~clk;

  bcd_chain #(.DIGITS(DIGITS)) uut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .cnt_en(cnt_en), .carry_in(carry_in), .load_val(load_val),
    .count(count), .digit_tc(digit_tc), .carry_out(carry_out)
  );

  task automatic check(input string tag, input logic [W-1:0] act_c,
                       input logic [W-1:0] exp_c, input logic [DIGITS-1:0] act_t,
                       input logic [DIGITS-1:0] exp_t_v, input logic act_o);
    n_run++;
    if (act_c !== exp_c || act_t !== exp_t_v || act_o !== exp_t_v[DIGITS-1]) begin
      n_fail++;
      $display("FAIL %s: count=%h tc=%b carry_out=%b, expected count=%h tc=%b carry_out=%b",
               tag, act_c, act_t, act_o, exp_c, exp_t_v, exp_t_v[DIGITS-1]);
    end
  endtask

  // Driver: apply inputs at the falling edge, push the state expected after the next rise
  task automatic step(input logic c_n, input logic l_n, input logic en,
                      input logic ci, input logic [W-1:0] d, input string tag);
    logic [3:0] nm [DIGITS];
    logic cet;
    exp_t e;
    @(negedge clk);
    clr_n = c_n; load_n = l_n; cnt_en = en; carry_in = ci; load_val = d;
    cet = ci;
    for (int i = 0; i < DIGITS; i++) begin
      if (!c_n)            nm[i] = 4'd0;
      else if (!l_n)       nm[i] = d[i*4 +: 4];
      else if (en && cet)  nm[i] = (m[i] >= 4'd9) ? 4'd0 : m[i] + 4'd1;
      else                 nm[i] = m[i];
      cet = cet && (m[i] == 4'd9);
    end
    cet = ci;
    for (int i = 0; i < DIGITS; i++) begin
      m[i] = nm[i];
      e.cnt[i*4 +: 4] = nm[i];
      e.tc[i] = cet && (nm[i] == 4'd9);
      cet = e.tc[i];
    end
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compare one item per rising edge, 1 ns after it
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, count, e.cnt, digit_tc, e.tc, carry_out);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: count=%h, expected end of run", count);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DIGITS; i++) m[i] = 4'd0;
    rst_n = 1'b0; clr_n = 1'b1; load_n = 1'b1; cnt_en = 1'b1;
    carry_in = 1'b1; load_val = 8'h37;
    repeat (3) @(negedge clk);
    check("R1 reset holds zero", count, 8'h00, digit_tc, 2'b00, carry_out);
    cnt_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", count, 8'h00, digit_tc, 2'b00, carry_out);

    // Replay: clear, load seven, count to 13, inhibit
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h55, "R2 clear beats load");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h07, "R3 load seven");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R4 count 8");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R7 count 9");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R5 R8 wrap into 10");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R4 count 11");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R4 count 12");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R4 count 13");
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R4 inhibit cnt_en");
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R4 inhibit carry_in");

    // Flag with load and clear
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h09, "R7 load nine flag");
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R7 hold nine flag");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R9 clear at nine");

    // Non-decimal codes
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h0C, "R6 load twelve no flag");
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R6 twelve held");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R6 twelve to zero");
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'hF0, "R3 load upper fifteen");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R6 upper fifteen kept");
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'hF9, "R3 load F9");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R6 R8 fifteen to zero on carry");

    // Full rollover
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h99, "R8 load 99 carry_out");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R8 rollover to 00");

    // Full decade on digit 0
    for (int k = 0; k < 10; k++)
      step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R5 decade walk");

    // Combinational carry_in path between edges
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h99, "R7 load 99 carry_in low");
    wait (sb_q.size() == 0);
    @(negedge clk);
    cnt_en = 1'b0; load_n = 1'b1; carry_in = 1'b0;
    #1;
    check("R7 carry_in low mid-cycle", count, 8'h99, digit_tc, 2'b00, carry_out);
    carry_in = 1'b1;
    #1;
    check("R7 carry_in high mid-cycle", count, 8'h99, digit_tc, 2'b11, carry_out);
    load_n = 1'b0;
    #0.3;
    check("R7 load_n ignored by flag", count, 8'h99, digit_tc, 2'b11, carry_out);
    load_n = 1'b1;

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule